// File: doc/BRIEF.md
# SDRAM Single-Access Sequencer

This block turns single-word host reads and writes into the command sequence a four-bank SDRAM expects. After reset it programs the device's mode register once, writing the CAS latency into the mode field. It then serves one access at a time with a closed-page pattern: open the row, issue the column command, wait out the read latency or the write recovery, close every bank, and wait the precharge time before it takes the next request.

The host presents a request together with a direction bit, a linear word address split as {bank, row, column}, and write data. Busy is high while the block cannot take a request. Read data comes back on a one-cycle valid strobe. On the memory side the block drives the four active-low command strobes, the bank select, a shared twelve-bit address bus and a data bus with an output enable. Row-to-column delay, write recovery and precharge wait are configuration inputs counted in clocks. CAS latency is taken only when the mode register is written.

Top module: `sdram_seq`

## Requirements
- R1: Commands are encoded on (cs_n, ras_n, cas_n, we_n) as NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010 and MODE-SET 0000. While reset is asserted, and until the mode-set is issued, the bus shows NOP, busy is 1, the output enable is 0 and the read strobe is 0.
- R2: The reset release is synchronised through two flops. Exactly one MODE-SET cycle is issued, on the third clock edge after release, with bank 0 and the address bus zero except bits 6..4, which carry cfg_cl. Busy is 0 from the next cycle.
- R3: A request seen at a clock edge while busy is 0 is accepted, and ACTIVATE follows in the next cycle with bank = host_addr[24:23] and address = row host_addr[22:11]. Requests made while busy is 1 have no effect on the command stream.
- R4: The column command issues exactly T_rcd cycles after ACTIVATE, with NOPs in between. T_x means the configured value x, with 0 treated as 1.
- R5: The column command keeps the activated bank and drives A9..A0 = host_addr[9:0], A10 = 0 and A11 = host_addr[10].
- R6: On a write, the WRITE command cycle is the only cycle with the output enable high, and sd_dq_out carries the host write data in that cycle.
- R7: On a read, sd_dq_in is sampled in the cycle T_cl after READ. The word appears on host_rdata in the next cycle with host_rvalid high for that one cycle.
- R8: PRECHARGE with A10 = 1 issues T_twr cycles after WRITE, or T_cl cycles after READ.
- R9: Busy stays 1 from ACTIVATE until T_trp cycles after PRECHARGE, and falls in that cycle. All cycles between commands are NOP.
- R10: Read timing uses the CAS latency captured at the mode-set. A later change of cfg_cl has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl | input | 3 | CAS latency written at mode-set |
| cfg_trcd | input | 4 | Row-to-column delay in clocks |
| cfg_twr | input | 4 | Write recovery in clocks |
| cfg_trp | input | 4 | Precharge wait in clocks |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 25 | Linear word address {bank, row, column} |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | One-cycle read data strobe |
| host_busy | output | 1 | Block cannot take a request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed row/column/mode address |
| sd_dq_out | output | 16 | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data returned by memory |

## Verification
Some rules are checked by assertions on every cycle:
- a single mode-set;
- activation only after an accepted request;
- the exact row-to-column gap;
- the bank held steady into the column command;
- one-cycle output-enable and read-valid pulses;
- the all-banks bit on precharge.

Other behaviour can only be shown by the bench's scenarios, where a behavioural memory model and timeline are compared against the ports every cycle:
- the column bus mapping that skips A10;
- data arriving exactly the CAS latency after a read;
- latency frozen at mode-set;
- zero settings treated as one;
- requests ignored while busy;
- a reset taken in the middle of an access.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_BOOT, ST_MRS, ST_IDLE, ST_ACT, ST_RCD, ST_COL, ST_LAT, ST_PRE, ST_RP
  } seq_state_e;
endpackage

// File: rtl/sdq_rst_sync.sv
module sdq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  // asserts at once, releases after STAGES edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdq_addr_map.sv
module sdq_addr_map #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  localparam int COL_W   = ROW_W - 1,
  localparam int HADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [HADDR_W-1:0] haddr,
  output logic [BANK_W-1:0]  bank,
  output logic [ROW_W-1:0]   row,
  output logic [ROW_W-1:0]   col_bus
);
  logic [COL_W-1:0] col;

  assign col  = haddr[COL_W-1:0];
  assign row  = haddr[COL_W +: ROW_W];
  assign bank = haddr[HADDR_W-1 -: BANK_W];

  // column bits fill the bus around the auto-precharge bit, which stays low
  for (genvar i = 0; i < ROW_W; i++) begin : g_col
    if (i < AP_BIT) begin : g_lo
      assign col_bus[i] = col[i];
    end else if (i == AP_BIT) begin : g_ap
      assign col_bus[i] = 1'b0;
    end else begin : g_hi
      assign col_bus[i] = col[i-1];
    end
  end
endmodule

// File: rtl/sdq_timer.sv
module sdq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int DATA_W = 16,
  parameter int CL_W   = 3,
  parameter int CNT_W  = 4,
  parameter int AP_BIT = 10,
  localparam int COL_W   = ROW_W - 1,
  localparam int HADDR_W = BANK_W + ROW_W + COL_W,
  localparam int CL_LSB  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CL_W-1:0]    cfg_cl,
  input  logic [CNT_W-1:0]   cfg_trcd,
  input  logic [CNT_W-1:0]   cfg_twr,
  input  logic [CNT_W-1:0]   cfg_trp,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               host_busy,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BANK_W-1:0]  sd_ba,
  output logic [ROW_W-1:0]   sd_a,
  output logic [DATA_W-1:0]  sd_dq_out,
  output logic               sd_dq_oe,
  input  logic [DATA_W-1:0]  sd_dq_in
);
  function automatic logic [CNT_W-1:0] floor1(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  logic rst_ni;
  sdq_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_ni));

  seq_state_e         state_q, state_d;
  logic               we_q;
  logic [HADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [CL_W-1:0]    cl_q;
  logic               acc_go, cap_en;

  assign acc_go = (state_q == ST_IDLE) && host_req;
  assign cap_en = (state_q == ST_PRE) && !we_q;

  // request and latency capture
  always_ff @(posedge clk) begin
    if (acc_go) begin
      we_q    <= host_we;
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
    if (state_q == ST_MRS) cl_q <= cfg_cl;
    if (cap_en) host_rdata <= sd_dq_in;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_BOOT;
      host_rvalid <= 1'b0;
    end else begin
      state_q     <= state_d;
      host_rvalid <= cap_en;
    end
  end

  logic [CNT_W-1:0] trcd_e, twr_e, trp_e, cl_e, lat_e;
  assign trcd_e = floor1(cfg_trcd);
  assign twr_e  = floor1(cfg_twr);
  assign trp_e  = floor1(cfg_trp);
  assign cl_e   = floor1(CNT_W'(cl_q));
  assign lat_e  = we_q ? twr_e : cl_e;

  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  sdq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_ni), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  // next state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_BOOT: state_d = ST_MRS;
      ST_MRS:  state_d = ST_IDLE;
      ST_IDLE: if (host_req) state_d = ST_ACT;
      ST_ACT: begin
        tmr_load = 1'b1;
        tmr_val  = trcd_e - CNT_W'(1);
        state_d  = (trcd_e == CNT_W'(1)) ? ST_COL : ST_RCD;
      end
      ST_RCD: if (tmr_last) state_d = ST_COL;
      ST_COL: begin
        tmr_load = 1'b1;
        tmr_val  = lat_e - CNT_W'(1);
        state_d  = (lat_e == CNT_W'(1)) ? ST_PRE : ST_LAT;
      end
      ST_LAT: if (tmr_last) state_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = trp_e - CNT_W'(1);
        state_d  = (trp_e == CNT_W'(1)) ? ST_IDLE : ST_RP;
      end
      ST_RP:   if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_BOOT;
    endcase
  end

  logic [BANK_W-1:0] map_bank;
  logic [ROW_W-1:0]  map_row, map_col;
  sdq_addr_map #(.BANK_W(BANK_W), .ROW_W(ROW_W), .AP_BIT(AP_BIT)) u_map (
    .haddr(addr_q), .bank(map_bank), .row(map_row), .col_bus(map_col)
  );

  // command decode
  sd_cmd_e           cmd_w;
  logic [ROW_W-1:0]  a_w;
  logic [BANK_W-1:0] ba_w;
  always_comb begin
    cmd_w = CMD_NOP;
    a_w   = '0;
    ba_w  = map_bank;
    unique case (state_q)
      ST_MRS: begin
        cmd_w = CMD_MRS;
        ba_w  = '0;
        a_w[CL_LSB +: CL_W] = cfg_cl;
      end
      ST_ACT: begin cmd_w = CMD_ACT; a_w = map_row; end
      ST_COL: begin cmd_w = we_q ? CMD_WR : CMD_RD; a_w = map_col; end
      ST_PRE: begin cmd_w = CMD_PRE; a_w[AP_BIT] = 1'b1; end
      default: ;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_w;
  assign sd_ba     = ba_w;
  assign sd_a      = a_w;
  assign sd_dq_out = wdata_q;
  assign sd_dq_oe  = (state_q == ST_COL) && we_q;
  assign host_busy = (state_q != ST_IDLE);

  // ---------------- assertions ----------------
  logic             mrs_done_q;
  logic [CNT_W:0]   gap_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mrs_done_q <= 1'b0;
      gap_q      <= '0;
    end else begin
      if (cmd_w == CMD_MRS) mrs_done_q <= 1'b1;
      if (cmd_w == CMD_ACT)  gap_q <= (CNT_W+1)'(1);
      else if (gap_q != '1)  gap_q <= gap_q + (CNT_W+1)'(1);
    end
  end

  p_mrs_once_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_w == CMD_MRS) |-> !mrs_done_q);

  p_act_after_req_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_w == CMD_ACT) |-> $past(host_req && !host_busy));

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_w == CMD_RD || cmd_w == CMD_WR) |-> (gap_q == {1'b0, trcd_e}));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_w == CMD_RD || cmd_w == CMD_WR) |-> $stable(sd_ba));

  p_oe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    sd_dq_oe |=> !sd_dq_oe);

  p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    host_rvalid |=> !host_rvalid);

  p_pre_all_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_w == CMD_PRE) |-> sd_a[AP_BIT]);
endmodule

// File: tb/sdram_seq_bench.sv
module sdram_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n;
  logic [2:0]  cfg_cl;
  logic [3:0]  cfg_trcd, cfg_twr, cfg_trp;
  logic        host_req, host_we;
  logic [24:0] host_addr;
  logic [15:0] host_wdata, host_rdata;
  logic        host_rvalid, host_busy;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [15:0] sd_dq_out, sd_dq_in;
  logic        sd_dq_oe;

  sdram_seq u_sdram_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd),
    .cfg_twr(cfg_twr), .cfg_trp(cfg_trp), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_busy(host_busy), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [24:0] addr;
    logic [15:0] data;
  } op_t;

  op_t         ops[$];
  logic [15:0] mem [logic [24:0]];
  int  n_cmp = 0, n_bad = 0;
  int  mode, boot_n, s;
  int  m_trcd, m_n, m_trp, m_cl;
  op_t cur;
  bit  noise;
  string scen;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] rd_mem(input logic [24:0] a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [24:0] mk(input int b, input int r, input int c);
    return {b[1:0], r[11:0], c[10:0]};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", tag, scen, what, got, exp, $time);
    end
  endtask

  // one cycle: compare outputs against the timeline model, then drive inputs
  task automatic tick();
    logic [3:0]  ecmd;
    logic [11:0] ea;
    logic [1:0]  eba;
    logic        eoe, erv, ebusy, idle, start;
    string       tg;
    int          total;
    @(negedge clk);
    ecmd = 4'b0111; ea = '0; eba = '0; eoe = 0; erv = 0; ebusy = 1; tg = "R1";
    idle = 0; start = 0; total = 0;
    if (mode == 1) begin
      boot_n++;
      if (boot_n == 3) begin
        ecmd = 4'b0000; ea = {5'b0, cfg_cl, 4'b0}; eba = 2'd0; tg = "R2";
        m_cl = eff(int'(cfg_cl));
      end else if (boot_n >= 4) begin
        mode = 2; s = -1;
      end
    end
    if (mode == 2) begin
      if (s >= 0) total = m_trcd + m_n + m_trp;
      idle  = (s < 0) || (s == total);
      ebusy = !idle;
      tg    = "R9";
      if (s >= 0) begin
        if (s == 0) begin
          ecmd = 4'b0011; eba = cur.addr[24:23]; ea = cur.addr[22:11]; tg = "R3";
        end else if (s == m_trcd) begin
          ecmd = cur.we ? 4'b0100 : 4'b0101; eba = cur.addr[24:23];
          ea = {cur.addr[10], 1'b0, cur.addr[9:0]}; tg = "R4";
          if (cur.we) begin eoe = 1; mem[cur.addr] = cur.data; end
        end else if (s == m_trcd + m_n) begin
          ecmd = 4'b0010; eba = cur.addr[24:23]; tg = "R8";
        end
        if (!cur.we && s == m_trcd + m_n + 1) erv = 1;
      end
    end
    chk(tg, "command", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, ecmd});
    if (ecmd != 4'b0111) begin
      chk("R5", "bank", {30'd0, sd_ba}, {30'd0, eba});
      if (ecmd == 4'b0010) chk("R8", "a10", {31'd0, sd_a[10]}, 32'd1);
      else                 chk(ecmd == 4'b0011 ? "R3" : (ecmd == 4'b0000 ? "R2" : "R5"),
                               "address", {20'd0, sd_a}, {20'd0, ea});
    end
    chk("R6", "dq_oe", {31'd0, sd_dq_oe}, {31'd0, eoe});
    if (eoe) chk("R6", "dq_out", {16'd0, sd_dq_out}, {16'd0, cur.data});
    chk("R9", "busy", {31'd0, host_busy}, {31'd0, ebusy});
    chk("R7", "rvalid", {31'd0, host_rvalid}, {31'd0, erv});
    if (erv) chk("R7", "rdata", {16'd0, host_rdata}, {16'd0, rd_mem(cur.addr)});

    // memory returns data only in the cycle CL after READ
    if (mode == 2 && s >= 0 && !cur.we && s == m_trcd + m_cl) sd_dq_in = rd_mem(cur.addr);
    else sd_dq_in = 16'hDEAD;

    host_req = 0; host_we = 0; host_addr = 25'h0F0F0F0; host_wdata = 16'hC3C3;
    if (mode == 2) begin
      if (idle && ops.size() > 0) begin
        cur = ops.pop_front();
        host_req = 1; host_we = cur.we; host_addr = cur.addr; host_wdata = cur.data;
        m_trcd = eff(int'(cfg_trcd)); m_trp = eff(int'(cfg_trp));
        m_n = cur.we ? eff(int'(cfg_twr)) : m_cl;
        start = 1;
      end else if (!idle && noise) begin
        host_req = 1; host_we = ~cur.we; host_addr = 25'h1555555; host_wdata = 16'h9999;
      end
      if (start) s = 0;
      else if (s >= 0 && s < total) s++;
      else s = -1;
    end
  endtask

  task automatic reset_and_boot(input logic [2:0] cl);
    rst_n = 0; mode = 0; cfg_cl = cl;
    repeat (3) tick();
    rst_n = 1; mode = 1; boot_n = 0;
  endtask

  task automatic drain();
    while (mode != 2 || ops.size() != 0 || s >= 0) tick();
    repeat (2) tick();
  endtask

  initial begin
    rst_n = 0; mode = 0; s = -1; noise = 0; boot_n = 0; m_cl = 1;
    m_trcd = 1; m_n = 1; m_trp = 1; cur = '0;
    cfg_cl = 3'd2; cfg_trcd = 4'd3; cfg_twr = 4'd2; cfg_trp = 4'd2;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0; sd_dq_in = '0;

    scen = "R1 R2 boot";
    reset_and_boot(3'd2);
    scen = "R5 R6 R7 mixed banks";
    ops.push_back('{1'b1, mk(1, 12'h123, 11'h405), 16'hA1B2});
    ops.push_back('{1'b0, mk(1, 12'h123, 11'h405), 16'h0});
    ops.push_back('{1'b0, mk(3, 12'h800, 11'h7FF), 16'h0});
    ops.push_back('{1'b1, mk(3, 12'h800, 11'h7FF), 16'h5E5E});
    ops.push_back('{1'b0, mk(3, 12'h800, 11'h7FF), 16'h0});
    drain();

    scen = "R3 minimal timing with requests while busy";
    cfg_trcd = 4'd1; cfg_twr = 4'd1; cfg_trp = 4'd1; noise = 1;
    ops.push_back('{1'b1, mk(0, 12'hFFF, 11'h3FF), 16'h1234});
    ops.push_back('{1'b0, mk(0, 12'hFFF, 11'h3FF), 16'h0});
    ops.push_back('{1'b1, mk(2, 12'h001, 11'h400), 16'hBEEF});
    ops.push_back('{1'b0, mk(2, 12'h001, 11'h400), 16'h0});
    drain();
    noise = 0;

    scen = "R4 R8 R9 zero settings act as one";
    cfg_trcd = 4'd0; cfg_twr = 4'd0; cfg_trp = 4'd0;
    ops.push_back('{1'b1, mk(1, 12'h0AA, 11'h055), 16'h7777});
    ops.push_back('{1'b0, mk(1, 12'h0AA, 11'h055), 16'h0});
    drain();

    scen = "R10 latency frozen at mode-set";
    cfg_trcd = 4'd2; cfg_twr = 4'd4; cfg_trp = 4'd3; cfg_cl = 3'd6;
    ops.push_back('{1'b0, mk(1, 12'h123, 11'h405), 16'h0});
    ops.push_back('{1'b1, mk(2, 12'h321, 11'h111), 16'h4242});
    ops.push_back('{1'b0, mk(2, 12'h321, 11'h111), 16'h0});
    drain();

    scen = "R1 reset during an access";
    ops.push_back('{1'b0, mk(0, 12'h010, 11'h020), 16'h0});
    while (ops.size() != 0) tick();
    repeat (2) tick();
    reset_and_boot(3'd3);
    scen = "R7 R8 latency three";
    cfg_trcd = 4'd2; cfg_twr = 4'd3; cfg_trp = 4'd3;
    ops.push_back('{1'b1, mk(3, 12'h456, 11'h7AB), 16'hF00D});
    ops.push_back('{1'b0, mk(3, 12'h456, 11'h7AB), 16'h0});
    ops.push_back('{1'b0, mk(1, 12'h123, 11'h405), 16'h0});
    drain();

    scen = "R2 R7 zero latency acts as one";
    reset_and_boot(3'd0);
    ops.push_back('{1'b1, mk(0, 12'h777, 11'h001), 16'h0F0F});
    ops.push_back('{1'b0, mk(0, 12'h777, 11'h001), 16'h0});
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule